// File: doc/BRIEF.md
# Directory Coherence Controller

This block is the central directory of a small distributed shared-memory system. For every memory block it keeps a sharing state (Uncached, Shared or Exclusive), a presence vector with one bit per node, and the block's memory word. Nodes send read-miss, write-miss and writeback requests. The controller looks up the block, sends invalidate or fetch messages to the nodes that hold copies, collects their acknowledgements or data, and then answers the requester. Write misses invalidate only the nodes listed in the presence vector. There is no broadcast.

The controller works on one transaction at a time. A request is accepted only when the previous one has finished, which gives the rule of one outstanding transaction per block. Every channel uses a valid/ready handshake. Outgoing messages to holders, responses from holders and replies to requesters each have their own channel.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector and memory word zero. `req_ready` is high, and `msg_valid`, `rpl_valid` and `rsp_ready` are low. Request kind encoding is 0 read miss, 1 write miss, 2 writeback.
- R2: A read miss on an Uncached or Shared block produces no message. It produces one reply carrying the memory word with `rpl_excl`=0. The block becomes Shared and the requester is added to its presence vector.
- R3: A read miss on a block held Exclusive by another node sends one message of kind 1 (fetch) to that owner. When that owner returns data (response kind 1), the data is written to memory and carried in the reply with `rpl_excl`=0. The block becomes Shared, held by the old owner and the requester.
- R4: A write miss on a Shared block sends one message of kind 0 (invalidate) to each holder other than the requester, in ascending node order. The reply (`rpl_excl`=1) comes only after an acknowledgement (response kind 0) has arrived from each of those nodes. Acknowledgements from other nodes are not counted. The block becomes Exclusive, held by the requester alone.
- R5: A write miss on an Uncached block produces no message. It produces an immediate reply with `rpl_excl`=1 and the memory word. The requester becomes the exclusive owner.
- R6: A write miss on a block held Exclusive by another node sends one message of kind 2 (fetch and invalidate) to the owner. The owner's returned data goes to memory and to the reply. The requester becomes the exclusive owner.
- R7: A writeback from the exclusive owner stores its data in memory and returns the block to Uncached with an empty presence vector. It sends no reply and no message.
- R8: A writeback from a node that is not the exclusive owner of the block has no effect on memory or on the directory.
- R9: Once a request is accepted, `req_ready` stays low until the reply handshake completes. For a writeback it stays low for exactly one cycle.
- R10: While `msg_valid` or `rpl_valid` is high and the matching ready is low, that channel's payload stays unchanged.
- R11: A read or write miss from the node that already owns the block exclusively produces no message. It produces a reply with `rpl_excl`=1 and the memory word, and the directory is left unchanged.
- R12: `rsp_ready` is high only while the controller waits for responses, and then neither `msg_valid` nor `rpl_valid` is high. `msg_valid` and `rpl_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller accepts a request |
| req_node | input | $clog2(NODES) | Requesting node |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 writeback |
| req_blk | input | $clog2(BLOCKS) | Block index |
| req_data | input | DATA_W | Writeback data |
| msg_valid | output | 1 | Message to a holder present |
| msg_ready | input | 1 | Network takes the message |
| msg_node | output | $clog2(NODES) | Target node |
| msg_kind | output | 2 | 0 invalidate, 1 fetch, 2 fetch and invalidate |
| msg_blk | output | $clog2(BLOCKS) | Block index |
| rsp_valid | input | 1 | Response from a holder present |
| rsp_ready | output | 1 | Controller takes the response |
| rsp_node | input | $clog2(NODES) | Responding node |
| rsp_kind | input | 1 | 0 acknowledgement, 1 data |
| rsp_data | input | DATA_W | Returned block data |
| rpl_valid | output | 1 | Reply to requester present |
| rpl_ready | input | 1 | Requester takes the reply |
| rpl_node | output | $clog2(NODES) | Requester |
| rpl_blk | output | $clog2(BLOCKS) | Block index |
| rpl_data | output | DATA_W | Block data |
| rpl_excl | output | 1 | 1 when exclusive ownership is granted |

## Verification
The bench focuses on the transitions where sharer bookkeeping goes wrong. A write miss by a node that is already a sharer must not invalidate the requester itself. A design that does so sends a message too many and waits for an acknowledgement that never comes. A stray acknowledgement from a node that was not invalidated is injected to catch a controller that counts responses instead of tracking who owes one; such a controller would reply early. Writebacks from non-owners, and reads after a fetch, show through later reply data whether memory and the presence vector were updated from the right source. Held ready signals expose a payload that drifts before the handshake.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        REQ_READ  = 2'd0,
        REQ_WRITE = 2'd1,
        REQ_WBACK = 2'd2,
        REQ_NONE  = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        MSG_INV       = 2'd0,
        MSG_FETCH     = 2'd1,
        MSG_FETCH_INV = 2'd2
    } msg_kind_e;

    typedef enum logic {
        RSP_ACK  = 1'b0,
        RSP_DATA = 1'b1
    } rsp_kind_e;

    typedef enum logic [1:0] {
        BLK_UNCACHED = 2'd0,
        BLK_SHARED   = 2'd1,
        BLK_EXCL     = 2'd2
    } blk_state_e;

    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_DECIDE,
        ENG_SEND_INV,
        ENG_WAIT_ACK,
        ENG_SEND_FETCH,
        ENG_WAIT_DATA,
        ENG_REPLY
    } eng_state_e;

    // True when the entry names the node as sole exclusive holder.
    function automatic logic holds_excl(blk_state_e st, logic present);
        return (st == BLK_EXCL) && present;
    endfunction

endpackage

// File: rtl/dir_pick.sv
// Finds the lowest set bit of a node vector.
module dir_pick #(
    parameter int NODES = 4,
    localparam int NW = $clog2(NODES)
) (
    input  logic [NODES-1:0] vec,
    output logic             found,
    output logic [NW-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = NW'(i);
            end
        end
    end
endmodule

// File: rtl/dir_store.sv
// Per-block directory entry and memory word.
module dir_store
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    parameter int DATA_W = 8,
    localparam int BW = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BW-1:0]     blk,
    output blk_state_e        rd_state,
    output logic [NODES-1:0]  rd_sharers,
    output logic [DATA_W-1:0] rd_data,
    input  logic              dir_we,
    input  blk_state_e        dir_wstate,
    input  logic [NODES-1:0]  dir_wsharers,
    input  logic              mem_we,
    input  logic [DATA_W-1:0] mem_wdata
);
    blk_state_e        state_q   [BLOCKS];
    logic [NODES-1:0]  sharers_q [BLOCKS];
    logic [DATA_W-1:0] mem_q     [BLOCKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BLOCKS; i++) begin
                state_q[i]   <= BLK_UNCACHED;
                sharers_q[i] <= '0;
                mem_q[i]     <= '0;
            end
        end else begin
            if (dir_we) begin
                state_q[blk]   <= dir_wstate;
                sharers_q[blk] <= dir_wsharers;
            end
            if (mem_we) begin
                mem_q[blk] <= mem_wdata;
            end
        end
    end

    assign rd_state   = state_q[blk];
    assign rd_sharers = sharers_q[blk];
    assign rd_data    = mem_q[blk];
endmodule

// File: rtl/dir_engine.sv
// Transaction sequencer: decide, message holders, collect, reply.
module dir_engine
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    parameter int DATA_W = 8,
    localparam int NW = $clog2(NODES),
    localparam int BW = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [NW-1:0]     req_node,
    input  logic [1:0]        req_kind,
    input  logic [BW-1:0]     req_blk,
    input  logic [DATA_W-1:0] req_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [NW-1:0]     msg_node,
    output logic [1:0]        msg_kind,
    output logic [BW-1:0]     msg_blk,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [NW-1:0]     rsp_node,
    input  logic              rsp_kind,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              rpl_valid,
    input  logic              rpl_ready,
    output logic [NW-1:0]     rpl_node,
    output logic [BW-1:0]     rpl_blk,
    output logic [DATA_W-1:0] rpl_data,
    output logic              rpl_excl,
    output logic [BW-1:0]     st_blk,
    input  blk_state_e        rd_state,
    input  logic [NODES-1:0]  rd_sharers,
    input  logic [DATA_W-1:0] rd_data,
    output logic              dir_we,
    output blk_state_e        dir_wstate,
    output logic [NODES-1:0]  dir_wsharers,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata
);
    eng_state_e        st;
    req_kind_e         cur_kind;
    logic [NW-1:0]     cur_node;
    logic [BW-1:0]     cur_blk;
    logic [DATA_W-1:0] cur_data;
    logic [NW-1:0]     owner_q;
    msg_kind_e         fkind_q;
    logic [NODES-1:0]  pend_q;
    logic [NODES-1:0]  wait_q;
    blk_state_e        upd_st;
    logic [NODES-1:0]  upd_sh;
    logic              excl_q;

    logic [NODES-1:0]  req_bit;
    logic [NODES-1:0]  inv_targets;
    logic [NODES-1:0]  pend_left;
    logic [NODES-1:0]  wait_left;
    logic              owner_found;
    logic [NW-1:0]     owner_idx;
    logic              pend_found;
    logic [NW-1:0]     pend_idx;
    logic              owner_hit;
    logic              other_owner;
    logic              wb_take;
    logic              data_take;
    logic              ack_take;

    dir_pick #(.NODES(NODES)) u_owner_pick (
        .vec   (rd_sharers),
        .found (owner_found),
        .idx   (owner_idx)
    );

    dir_pick #(.NODES(NODES)) u_inv_pick (
        .vec   (pend_q),
        .found (pend_found),
        .idx   (pend_idx)
    );

    assign req_bit     = NODES'(1) << cur_node;
    assign inv_targets = rd_sharers & ~req_bit;
    assign pend_left   = pend_q & ~(NODES'(1) << pend_idx);
    assign wait_left   = wait_q & ~(NODES'(1) << rsp_node);
    assign owner_hit   = holds_excl(rd_state, rd_sharers[cur_node]);
    assign other_owner = (rd_state == BLK_EXCL) && owner_found && !owner_hit;
    assign wb_take     = (st == ENG_DECIDE) && (cur_kind == REQ_WBACK) && owner_hit;
    assign data_take   = (st == ENG_WAIT_DATA) && rsp_valid
                         && (rsp_kind_e'(rsp_kind) == RSP_DATA) && (rsp_node == owner_q);
    assign ack_take    = (st == ENG_WAIT_ACK) && rsp_valid
                         && (rsp_kind_e'(rsp_kind) == RSP_ACK) && wait_q[rsp_node];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ENG_IDLE;
            cur_kind <= REQ_NONE;
            cur_node <= '0;
            cur_blk  <= '0;
            cur_data <= '0;
            owner_q  <= '0;
            fkind_q  <= MSG_FETCH;
            pend_q   <= '0;
            wait_q   <= '0;
            upd_st   <= BLK_UNCACHED;
            upd_sh   <= '0;
            excl_q   <= 1'b0;
        end else begin
            case (st)
                ENG_IDLE: begin
                    if (req_valid) begin
                        cur_node <= req_node;
                        cur_kind <= req_kind_e'(req_kind);
                        cur_blk  <= req_blk;
                        cur_data <= req_data;
                        st       <= ENG_DECIDE;
                    end
                end
                ENG_DECIDE: begin
                    case (cur_kind)
                        REQ_READ: begin
                            upd_st <= owner_hit ? BLK_EXCL : BLK_SHARED;
                            upd_sh <= owner_hit ? rd_sharers : (rd_sharers | req_bit);
                            excl_q <= owner_hit;
                            if (other_owner) begin
                                owner_q <= owner_idx;
                                fkind_q <= MSG_FETCH;
                                st      <= ENG_SEND_FETCH;
                            end else begin
                                st <= ENG_REPLY;
                            end
                        end
                        REQ_WRITE: begin
                            upd_st <= BLK_EXCL;
                            upd_sh <= req_bit;
                            excl_q <= 1'b1;
                            if ((rd_state == BLK_SHARED) && (inv_targets != '0)) begin
                                pend_q <= inv_targets;
                                wait_q <= inv_targets;
                                st     <= ENG_SEND_INV;
                            end else if (other_owner) begin
                                owner_q <= owner_idx;
                                fkind_q <= MSG_FETCH_INV;
                                st      <= ENG_SEND_FETCH;
                            end else begin
                                st <= ENG_REPLY;
                            end
                        end
                        default: st <= ENG_IDLE;
                    endcase
                end
                ENG_SEND_INV: begin
                    if (msg_ready && pend_found) begin
                        pend_q <= pend_left;
                        if (pend_left == '0) begin
                            st <= ENG_WAIT_ACK;
                        end
                    end
                end
                ENG_WAIT_ACK: begin
                    if (ack_take) begin
                        wait_q <= wait_left;
                        if (wait_left == '0) begin
                            st <= ENG_REPLY;
                        end
                    end
                end
                ENG_SEND_FETCH: begin
                    if (msg_ready) begin
                        st <= ENG_WAIT_DATA;
                    end
                end
                ENG_WAIT_DATA: begin
                    if (data_take) begin
                        st <= ENG_REPLY;
                    end
                end
                ENG_REPLY: begin
                    if (rpl_ready) begin
                        st <= ENG_IDLE;
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    assign req_ready = (st == ENG_IDLE);
    assign msg_valid = ((st == ENG_SEND_INV) && pend_found) || (st == ENG_SEND_FETCH);
    assign msg_node  = (st == ENG_SEND_INV) ? pend_idx : owner_q;
    assign msg_kind  = (st == ENG_SEND_INV) ? MSG_INV : fkind_q;
    assign msg_blk   = cur_blk;
    assign rsp_ready = (st == ENG_WAIT_ACK) || (st == ENG_WAIT_DATA);
    assign rpl_valid = (st == ENG_REPLY);
    assign rpl_node  = cur_node;
    assign rpl_blk   = cur_blk;
    assign rpl_data  = rd_data;
    assign rpl_excl  = excl_q;

    assign st_blk       = cur_blk;
    assign dir_we       = wb_take || ((st == ENG_REPLY) && rpl_ready);
    assign dir_wstate   = (st == ENG_REPLY) ? upd_st : BLK_UNCACHED;
    assign dir_wsharers = (st == ENG_REPLY) ? upd_sh : '0;
    assign mem_we       = wb_take || data_take;
    assign mem_wdata    = (st == ENG_WAIT_DATA) ? rsp_data : cur_data;
endmodule

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl
    import dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 16,
    parameter int DATA_W = 8,
    localparam int NW = $clog2(NODES),
    localparam int BW = $clog2(BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [NW-1:0]     req_node,
    input  logic [1:0]        req_kind,
    input  logic [BW-1:0]     req_blk,
    input  logic [DATA_W-1:0] req_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [NW-1:0]     msg_node,
    output logic [1:0]        msg_kind,
    output logic [BW-1:0]     msg_blk,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    input  logic [NW-1:0]     rsp_node,
    input  logic              rsp_kind,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              rpl_valid,
    input  logic              rpl_ready,
    output logic [NW-1:0]     rpl_node,
    output logic [BW-1:0]     rpl_blk,
    output logic [DATA_W-1:0] rpl_data,
    output logic              rpl_excl
);
    logic [BW-1:0]     st_blk;
    blk_state_e        rd_state;
    logic [NODES-1:0]  rd_sharers;
    logic [DATA_W-1:0] rd_data;
    logic              dir_we;
    blk_state_e        dir_wstate;
    logic [NODES-1:0]  dir_wsharers;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;

    dir_store #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_store (
        .clk          (clk),
        .rst          (rst),
        .blk          (st_blk),
        .rd_state     (rd_state),
        .rd_sharers   (rd_sharers),
        .rd_data      (rd_data),
        .dir_we       (dir_we),
        .dir_wstate   (dir_wstate),
        .dir_wsharers (dir_wsharers),
        .mem_we       (mem_we),
        .mem_wdata    (mem_wdata)
    );

    dir_engine #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_node     (req_node),
        .req_kind     (req_kind),
        .req_blk      (req_blk),
        .req_data     (req_data),
        .msg_valid    (msg_valid),
        .msg_ready    (msg_ready),
        .msg_node     (msg_node),
        .msg_kind     (msg_kind),
        .msg_blk      (msg_blk),
        .rsp_valid    (rsp_valid),
        .rsp_ready    (rsp_ready),
        .rsp_node     (rsp_node),
        .rsp_kind     (rsp_kind),
        .rsp_data     (rsp_data),
        .rpl_valid    (rpl_valid),
        .rpl_ready    (rpl_ready),
        .rpl_node     (rpl_node),
        .rpl_blk      (rpl_blk),
        .rpl_data     (rpl_data),
        .rpl_excl     (rpl_excl),
        .st_blk       (st_blk),
        .rd_state     (rd_state),
        .rd_sharers   (rd_sharers),
        .rd_data      (rd_data),
        .dir_we       (dir_we),
        .dir_wstate   (dir_wstate),
        .dir_wsharers (dir_wsharers),
        .mem_we       (mem_we),
        .mem_wdata    (mem_wdata)
    );
endmodule

// File: rtl/dir_checker.sv
module dir_checker #(
    parameter int NW = 2,
    parameter int BW = 4,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          msg_valid,
    input logic          msg_ready,
    input logic [NW-1:0] msg_node,
    input logic [1:0]    msg_kind,
    input logic [BW-1:0] msg_blk,
    input logic          rsp_ready,
    input logic          rpl_valid,
    input logic          rpl_ready,
    input logic [NW-1:0] rpl_node,
    input logic [BW-1:0] rpl_blk,
    input logic [DW-1:0] rpl_data,
    input logic          rpl_excl
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!msg_valid && !rpl_valid && !rsp_ready && req_ready));

    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_no_accept_in_flight_r9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid || rpl_valid) |-> !req_ready);

    p_msg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_node)
                                       && $stable(msg_kind) && $stable(msg_blk)));

    p_rpl_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rpl_valid && !rpl_ready) |=> (rpl_valid && $stable(rpl_node) && $stable(rpl_blk)
                                       && $stable(rpl_data) && $stable(rpl_excl)));

    p_rsp_alone_r12: assert property (@(posedge clk) disable iff (rst)
        rsp_ready |-> (!msg_valid && !rpl_valid));

    p_one_output_r12: assert property (@(posedge clk) disable iff (rst)
        !(msg_valid && rpl_valid));
endmodule

bind dir_coherence_ctrl dir_checker #(.NW(NW), .BW(BW), .DW(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_node  (msg_node),
    .msg_kind  (msg_kind),
    .msg_blk   (msg_blk),
    .rsp_ready (rsp_ready),
    .rpl_valid (rpl_valid),
    .rpl_ready (rpl_ready),
    .rpl_node  (rpl_node),
    .rpl_blk   (rpl_blk),
    .rpl_data  (rpl_data),
    .rpl_excl  (rpl_excl)
);

// File: tb/dir_coherence_ctrl_bench.sv
module dir_coherence_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NODES  = 4;
    localparam int BLOCKS = 16;
    localparam int DATA_W = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_node = '0;
    logic [1:0] req_kind = '0;
    logic [3:0] req_blk = '0;
    logic [7:0] req_data = '0;
    logic       msg_valid;
    logic       msg_ready = 1'b1;
    logic [1:0] msg_node;
    logic [1:0] msg_kind;
    logic [3:0] msg_blk;
    logic       rsp_valid = 1'b0;
    logic       rsp_ready;
    logic [1:0] rsp_node = '0;
    logic       rsp_kind = 1'b0;
    logic [7:0] rsp_data = '0;
    logic       rpl_valid;
    logic       rpl_ready = 1'b1;
    logic [1:0] rpl_node;
    logic [3:0] rpl_blk;
    logic [7:0] rpl_data;
    logic       rpl_excl;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    bit busy_m  = 1'b0;
    bit wb_once = 1'b0;

    int         m_st  [BLOCKS];
    logic [3:0] m_sh  [BLOCKS];
    logic [7:0] m_mem [BLOCKS];

    logic [15:0] msg_q [$];
    logic [15:0] rpl_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dir_coherence_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_dir_coherence_ctrl (
        .clk (clk), .rst (rst),
        .req_valid (req_valid), .req_ready (req_ready), .req_node (req_node),
        .req_kind (req_kind), .req_blk (req_blk), .req_data (req_data),
        .msg_valid (msg_valid), .msg_ready (msg_ready), .msg_node (msg_node),
        .msg_kind (msg_kind), .msg_blk (msg_blk),
        .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_node (rsp_node),
        .rsp_kind (rsp_kind), .rsp_data (rsp_data),
        .rpl_valid (rpl_valid), .rpl_ready (rpl_ready), .rpl_node (rpl_node),
        .rpl_blk (rpl_blk), .rpl_data (rpl_data), .rpl_excl (rpl_excl)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    function automatic int lowest(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (v[i]) return i;
        return 0;
    endfunction

    // Per-cycle reference comparison of handshake-level behaviour.
    always @(negedge clk) begin
        if (!rst) begin
            chk(req_ready == !busy_m, "R9", "req_ready", int'(req_ready), int'(!busy_m));
            chk(!(msg_valid && rpl_valid), "R12", "msg and reply together",
                int'(msg_valid && rpl_valid), 0);
            chk(!(rsp_ready && (msg_valid || rpl_valid)), "R12", "rsp_ready overlap",
                int'(rsp_ready), 0);
            if (wb_once) begin busy_m = 1'b0; wb_once = 1'b0; end
            if (req_valid && req_ready) begin
                busy_m  = 1'b1;
                wb_once = (req_kind == 2'd2);
            end
            if (msg_valid && msg_ready) msg_q.push_back({8'd0, msg_node, msg_kind, msg_blk});
            if (rpl_valid && rpl_ready) begin
                busy_m = 1'b0;
                rpl_q.push_back({1'b0, rpl_data, rpl_excl, rpl_node, rpl_blk});
            end
        end
    end

    task automatic send_req(input int n, input int k, input int b, input int d);
        @(posedge clk); #1;
        req_node = 2'(n); req_kind = 2'(k); req_blk = 4'(b); req_data = 8'(d);
        req_valid = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ready) begin
                @(posedge clk); #1;
                req_valid = 1'b0;
                break;
            end
        end
    endtask

    task automatic send_rsp(input int n, input int k, input int d);
        @(posedge clk); #1;
        rsp_node = 2'(n); rsp_kind = 1'(k); rsp_data = 8'(d);
        rsp_valid = 1'b1;
        for (int t = 0; t < 100; t++) begin
            @(negedge clk);
            if (rsp_ready) begin
                @(posedge clk); #1;
                break;
            end
        end
        rsp_valid = 1'b0;
    endtask

    task automatic get_msg(output logic [15:0] e, output bit ok);
        int t = 0;
        while (msg_q.size() == 0 && t < 100) begin @(negedge clk); #1; t++; end
        ok = (msg_q.size() > 0);
        e  = ok ? msg_q.pop_front() : 16'd0;
    endtask

    task automatic get_rpl(output logic [15:0] e, output bit ok);
        int t = 0;
        while (rpl_q.size() == 0 && t < 100) begin @(negedge clk); #1; t++; end
        ok = (rpl_q.size() > 0);
        e  = ok ? rpl_q.pop_front() : 16'd0;
    endtask

    // mode: 0 plain, 1 hold reply ready, 2 hold message ready, 3 stray ack first
    task automatic txn(input int n, input int k, input int b, input int wd,
                       input int fd, input int mode, input string tag);
        int st, owner, exp_excl, t;
        logic [3:0] sh, rb, tg;
        logic [15:0] e, snap;
        bit own_hit, ok, fetch;
        int en[$];
        int ek[$];
        st = m_st[b]; sh = m_sh[b]; rb = 4'(1 << n);
        owner = lowest(sh);
        own_hit = (st == 2) && sh[n];
        tg = '0; fetch = 1'b0;
        if (k == 0 && st == 2 && !own_hit) begin en.push_back(owner); ek.push_back(1); fetch = 1'b1; end
        if (k == 1 && st == 1) begin
            tg = sh & ~rb;
            for (int i = 0; i < 4; i++) if (tg[i]) begin en.push_back(i); ek.push_back(0); end
        end
        if (k == 1 && st == 2 && !own_hit) begin en.push_back(owner); ek.push_back(2); fetch = 1'b1; end
        if (mode == 1) rpl_ready = 1'b0;
        if (mode == 2) msg_ready = 1'b0;
        send_req(n, k, b, wd);
        if (mode == 2) begin
            t = 0;
            while (!msg_valid && t < 50) begin @(negedge clk); t++; end
            snap = {8'd0, msg_node, msg_kind, msg_blk};
            repeat (3) @(negedge clk);
            chk(msg_valid && ({8'd0, msg_node, msg_kind, msg_blk} == snap), "R10",
                "message held under back-pressure", int'({msg_node, msg_kind, msg_blk}), int'(snap));
            @(posedge clk); #1;
            msg_ready = 1'b1;
        end
        for (int i = 0; i < en.size(); i++) begin
            get_msg(e, ok);
            chk(ok, tag, "message present", int'(ok), 1);
            if (ok) begin
                chk(int'(e[7:6]) == en[i], tag, "message node", int'(e[7:6]), en[i]);
                chk(int'(e[5:4]) == ek[i], tag, "message kind", int'(e[5:4]), ek[i]);
                chk(int'(e[3:0]) == b, tag, "message block", int'(e[3:0]), b);
            end
        end
        if (mode == 3) begin
            send_rsp(n, 0, 0);
            repeat (3) @(negedge clk);
            chk(rpl_q.size() == 0 && !rpl_valid, "R4", "reply after stray ack",
                int'(rpl_valid), 0);
        end
        for (int i = 0; i < 4; i++) if (tg[i]) send_rsp(i, 0, 0);
        if (fetch) begin
            send_rsp(owner, 1, fd);
            m_mem[b] = 8'(fd);
        end
        if (k == 2) begin
            repeat (4) @(negedge clk);
            chk(rpl_q.size() == 0, tag, "no reply to writeback", rpl_q.size(), 0);
            if (own_hit) begin m_mem[b] = 8'(wd); m_st[b] = 0; m_sh[b] = '0; end
        end else begin
            if (mode == 1) begin
                t = 0;
                while (!rpl_valid && t < 100) begin @(negedge clk); t++; end
                snap = {1'b0, rpl_data, rpl_excl, rpl_node, rpl_blk};
                repeat (3) @(negedge clk);
                chk(rpl_valid && ({1'b0, rpl_data, rpl_excl, rpl_node, rpl_blk} == snap), "R10",
                    "reply held under back-pressure", int'(rpl_data), int'(snap[14:7]));
                @(posedge clk); #1;
                rpl_ready = 1'b1;
            end
            exp_excl = (k == 1 || own_hit) ? 1 : 0;
            get_rpl(e, ok);
            chk(ok, tag, "reply present", int'(ok), 1);
            if (ok) begin
                chk(int'(e[5:4]) == n, tag, "reply node", int'(e[5:4]), n);
                chk(int'(e[3:0]) == b, tag, "reply block", int'(e[3:0]), b);
                chk(e[14:7] == m_mem[b], tag, "reply data", int'(e[14:7]), int'(m_mem[b]));
                chk(int'(e[6]) == exp_excl, tag, "reply exclusive", int'(e[6]), exp_excl);
            end
            if (!own_hit) begin
                if (k == 0) begin m_st[b] = 1; m_sh[b] = sh | rb; end
                else begin m_st[b] = 2; m_sh[b] = rb; end
            end
        end
        chk(msg_q.size() == 0, tag, "no extra message", msg_q.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < BLOCKS; i++) begin m_st[i] = 0; m_sh[i] = '0; m_mem[i] = '0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !msg_valid && !rpl_valid && !rsp_ready, "R1", "idle after reset",
            int'({req_ready, msg_valid, rpl_valid, rsp_ready}), 8);
        txn(0, 0, 3, 0, 0, 0, "R1 R2 read uncached");
        txn(1, 0, 3, 0, 0, 0, "R2 read shared");
        txn(2, 0, 3, 0, 0, 0, "R2 read shared");
        txn(1, 1, 3, 0, 0, 3, "R4 write shared");
        txn(3, 0, 3, 0, 8'hA5, 0, "R3 read exclusive");
        txn(2, 1, 5, 0, 0, 0, "R5 write uncached");
        txn(0, 1, 5, 0, 8'h3C, 2, "R6 write exclusive");
        txn(1, 2, 5, 8'hEE, 0, 0, "R8 writeback non-owner");
        txn(0, 0, 5, 0, 0, 0, "R11 read by owner");
        txn(0, 1, 5, 0, 0, 0, "R11 write by owner");
        txn(0, 2, 5, 8'h77, 0, 0, "R7 writeback owner");
        txn(2, 0, 5, 0, 0, 0, "R7 read after writeback");
        txn(3, 2, 3, 8'h11, 0, 0, "R8 writeback while shared");
        txn(0, 0, 3, 0, 0, 1, "R2 read shared held reply");
        txn(0, 1, 3, 0, 0, 0, "R4 write by sharer");
        for (int b = 8; b < 12; b++) begin
            txn(b % 4, 1, b, 0, 0, 0, "R5 write loop");
            txn((b + 1) % 4, 0, b, 0, b * 7, 0, "R3 read loop");
            txn((b + 2) % 4, 1, b, 0, 0, 0, "R4 write loop");
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule